// File: doc/BRIEF.md
# Dual-Bank Interrupt Aggregation Controller

This controller takes 64 asynchronous interrupt lines, sorts them into two 32-bit banks and drives a single combined interrupt request to a processor. Each line passes through a flop synchroniser. Most lines are edge sources: a rising edge sets a sticky event bit, and that bit stays set until software acknowledges it. A fixed group of lines in bank 1 are level sources. They are never latched and request service only while they are high.

Software reaches each bank through a small 32-bit register window. It can read the latched events, the enable mask and the live line levels. It can write the mask, and it can write ones to an acknowledge port to clear events. Data crosses the bus with its four bytes in reverse order, in both directions. Read data is registered and appears one clock after the address.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the events, mask and levels registers of both banks are zero, the interrupt output is low and the read data is zero.
- R2: Input line N (0..63) belongs to bank (1 - N[5]) at bit N[4:0]. Lines 0-31 therefore fill bank 1 and lines 32-63 fill bank 0.
- R3: A change on an input line reaches the levels register, and a rising edge reaches the events register, on the third rising clock edge after the change. The output follows combinationally from those registers.
- R4: On an edge-type bit, a rising line edge sets the event bit. The event bit stays set when the line falls and clears only through an acknowledge.
- R5: Bits 20 to 28 of bank 1 (0x1FF00000) are level-type. Their event bits never set. Every other bit of both banks is edge-type. The levels register always mirrors the synchronised lines.
- R6: A bank is pending when ((events | (levels & levelType)) & mask) is nonzero. The output is high exactly when at least one bank is pending.
- R7: Writing the mask port loads the mask register. Reading the mask port returns the stored mask.
- R8: An acknowledge write clears the event bits that are set in the written word, except for level-type bits, which are not affected. If a rising edge is captured on a bit in the same cycle as its acknowledge, the event bit stays set.
- R9: The bank index is (addr[11:0] - 0x10) >> 4, so bank 0 is at 0x10-0x1F and bank 1 at 0x20-0x2F. Within a bank the offsets are: 0x0 reads events, 0x4 reads and writes the mask, 0x8 is the write-only acknowledge port (reads zero), and 0xC reads levels. Any other address reads zero and ignores writes.
- R10: Bus data is the register value with byte order reversed (bus[31:24] = reg[7:0], and so on), both on reads and on writes.
- R11: Read data is registered. It reflects the address presented in the previous cycle and the register contents before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqIn | input | 64 | Asynchronous interrupt lines |
| busAddr | input | 12 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data (byte-reversed) |
| busRdData | output | 32 | Registered read data (byte-reversed) |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: a two-stage synchroniser and the level-type group at bank 1 bits 20-28. This setting puts both an all-edge bank and a mixed bank within reach. It also makes the three-edge input latency countable at the output. Random line flips, mask writes, acknowledges and reads from arbitrary addresses run against a reference model. Directed cases cover the reversed bank mapping, acknowledges aimed at level bits, an acknowledge that collides with a capture, and the byte order on the bus.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int WORD_W   = 32;
  localparam int BANK_CNT = 2;
  localparam int LINE_CNT = WORD_W * BANK_CNT;
  localparam int ADDR_W   = 12;
  localparam int BYTE_CNT = WORD_W / 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EVT  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_LVL  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic [BANK_CNT-1:0] maskWe;
    logic [BANK_CNT-1:0] ackWe;
    rdSel_e              rdSel;
    logic                rdBank;
    logic [WORD_W-1:0]   wrWord;
  } strobe_t;

  function automatic logic [WORD_W-1:0] laneSwap(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < BYTE_CNT; i++) begin
      r[i*8 +: 8] = v[(BYTE_CNT-1-i)*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_BASE = 12'h010,
  parameter int                STRIDE_SH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [WORD_W-1:0] busWrData,
  output strobe_t           stb
);
  localparam int OFF_W = STRIDE_SH;
  localparam logic [OFF_W-1:0] OFF_EVT  = OFF_W'(4'h0);
  localparam logic [OFF_W-1:0] OFF_MASK = OFF_W'(4'h4);
  localparam logic [OFF_W-1:0] OFF_ACK  = OFF_W'(4'h8);
  localparam logic [OFF_W-1:0] OFF_LVL  = OFF_W'(4'hC);

  logic [ADDR_W-1:0] relAddr;
  logic [ADDR_W-1:0] bankIdx;
  logic              inRange;
  logic [OFF_W-1:0]  offs;

  always_comb begin
    relAddr = busAddr - WIN_BASE;
    bankIdx = relAddr >> STRIDE_SH;
    inRange = (bankIdx < ADDR_W'(BANK_CNT));
    offs    = busAddr[OFF_W-1:0];

    stb        = '0;
    stb.wrWord = laneSwap(busWrData);
    stb.rdBank = relAddr[STRIDE_SH];
    if (inRange) begin
      if (busWrEn && offs == OFF_MASK) stb.maskWe[relAddr[STRIDE_SH]] = 1'b1;
      if (busWrEn && offs == OFF_ACK)  stb.ackWe[relAddr[STRIDE_SH]]  = 1'b1;
      case (offs)
        OFF_EVT:  stb.rdSel = SEL_EVT;
        OFF_MASK: stb.rdSel = SEL_MASK;
        OFF_LVL:  stb.rdSel = SEL_LVL;
        default:  stb.rdSel = SEL_NONE;
      endcase
    end
  end

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.maskWe, stb.ackWe}));

  assert_write_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |-> (stb.maskWe == '0 && stb.ackWe == '0));
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter logic [WORD_W-1:0] LVL_MASK_B0 = 32'h0000_0000,
  parameter logic [WORD_W-1:0] LVL_MASK_B1 = 32'h1FF0_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LINE_CNT-1:0] lineSync,
  input  strobe_t             stb,
  output logic [WORD_W-1:0]   rdData,
  output logic                irqOut
);
  localparam logic [WORD_W-1:0] LVL_SEL [BANK_CNT] = '{LVL_MASK_B0, LVL_MASK_B1};

  logic [WORD_W-1:0] bankIn   [BANK_CNT];
  logic [WORD_W-1:0] evtReg   [BANK_CNT];
  logic [WORD_W-1:0] maskReg  [BANK_CNT];
  logic [WORD_W-1:0] lvlReg   [BANK_CNT];
  logic [WORD_W-1:0] captureW [BANK_CNT];
  logic [WORD_W-1:0] ackBits  [BANK_CNT];
  logic [BANK_CNT-1:0] pend;

  genvar b;
  generate
    for (b = 0; b < BANK_CNT; b++) begin : gBank
      // reversed mapping: the upper line group feeds bank 0
      assign bankIn[b]   = lineSync[(BANK_CNT-1-b)*WORD_W +: WORD_W];
      assign captureW[b] = bankIn[b] & ~lvlReg[b] & ~LVL_SEL[b];
      assign ackBits[b]  = stb.ackWe[b] ? (stb.wrWord & ~LVL_SEL[b]) : '0;
      assign pend[b]     = |((evtReg[b] | (lvlReg[b] & LVL_SEL[b])) & maskReg[b]);

      assert_level_unlatched_R5: assert property (@(posedge clk) disable iff (!rstN)
        (evtReg[b] & LVL_SEL[b]) == '0);

      assert_event_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
        (|($past(evtReg[b]) & ~evtReg[b])) |-> $past(stb.ackWe[b]));

      assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rstN)
        stb.maskWe[b] |=> maskReg[b] == $past(stb.wrWord));

      assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
        stb.ackWe[b] |=> (evtReg[b] & $past(stb.wrWord & ~LVL_SEL[b] & ~captureW[b])) == '0);

      assert_capture_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
        (|captureW[b]) |=> (evtReg[b] & $past(captureW[b])) == $past(captureW[b]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BANK_CNT; i++) begin
        evtReg[i]  <= '0;
        maskReg[i] <= '0;
        lvlReg[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < BANK_CNT; i++) begin
        evtReg[i] <= (evtReg[i] & ~ackBits[i]) | captureW[i];
        lvlReg[i] <= bankIn[i];
        if (stb.maskWe[i]) maskReg[i] <= stb.wrWord;
      end
    end
  end

  logic [WORD_W-1:0] rdWord;
  always_comb begin
    case (stb.rdSel)
      SEL_EVT:  rdWord = evtReg[stb.rdBank];
      SEL_MASK: rdWord = maskReg[stb.rdBank];
      SEL_LVL:  rdWord = lvlReg[stb.rdBank];
      default:  rdWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= laneSwap(rdWord);
  end

  assign irqOut = |pend;

  assert_idle_read_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdSel == SEL_NONE |=> rdData == '0);

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg[0] == '0 && maskReg[1] == '0) |-> !irqOut);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] LVL_MASK_B0 = 32'h0000_0000,
  parameter logic [WORD_W-1:0] LVL_MASK_B1 = 32'h1FF0_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LINE_CNT-1:0] irqIn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [WORD_W-1:0]   busWrData,
  output logic [WORD_W-1:0]   busRdData,
  output logic                irqOut
);
  logic [LINE_CNT-1:0] lineSync;
  strobe_t             stb;

  irq_agg_sync #(.WIDTH(LINE_CNT), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .din(irqIn), .dout(lineSync)
  );

  irq_agg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .stb(stb)
  );

  irq_agg_datapath #(.LVL_MASK_B0(LVL_MASK_B0), .LVL_MASK_B1(LVL_MASK_B1)) uDp (
    .clk(clk), .rstN(rstN), .lineSync(lineSync), .stb(stb),
    .rdData(busRdData), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] irqIn = '0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [31:0] LVL1 = 32'h1FF0_0000;

  logic [31:0] mEvt [2];
  logic [31:0] mMask [2];
  logic [31:0] mLvl [2];

  irq_aggregator dut (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] sw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] lvlType(input int b);
    return (b == 1) ? LVL1 : 32'h0;
  endfunction

  function automatic logic [31:0] bankOf(input logic [63:0] v, input int b);
    return (b == 0) ? v[63:32] : v[31:0];
  endfunction

  function automatic logic expIrq();
    logic r = 1'b0;
    for (int b = 0; b < 2; b++)
      r |= |((mEvt[b] | (mLvl[b] & lvlType(b))) & mMask[b]);
    return r;
  endfunction

  function automatic logic [31:0] expRead(input logic [11:0] a);
    logic [11:0] rel = a - 12'h010;
    int idx = int'(rel >> 4);
    if (idx >= 2) return 32'h0;
    case (a[3:0])
      4'h0: return sw(mEvt[idx]);
      4'h4: return sw(mMask[idx]);
      4'hC: return sw(mLvl[idx]);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [11:0] a, input logic [31:0] d);
    logic [11:0] rel = a - 12'h010;
    int idx = int'(rel >> 4);
    if (idx < 2) begin
      if (a[3:0] == 4'h4) mMask[idx] = sw(d);
      if (a[3:0] == 4'h8) mEvt[idx] &= ~(sw(d) & ~lvlType(idx));
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic readChk(input string req, input logic [11:0] a);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b0;
    @(negedge clk);
    chk(req, busRdData, expRead(a));
  endtask

  // drive lines and wait for the three-edge latency, then update the model
  task automatic setLines(input logic [63:0] v);
    @(negedge clk);
    irqIn = v;
    repeat (3) @(negedge clk);
    for (int b = 0; b < 2; b++) begin
      mEvt[b] |= bankOf(v, b) & ~mLvl[b] & ~lvlType(b);
      mLvl[b] = bankOf(v, b);
    end
  endtask

  task automatic readAll(input string req);
    readChk(req, 12'h010); readChk(req, 12'h014); readChk(req, 12'h01C);
    readChk(req, 12'h020); readChk(req, 12'h024); readChk(req, 12'h02C);
  endtask

  initial begin
    for (int b = 0; b < 2; b++) begin mEvt[b] = 0; mMask[b] = 0; mLvl[b] = 0; end
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 irq at reset", 32'(irqOut), 32'(1'b0));
    chk("R1 rdData at reset", busRdData, 32'h0);
    rstN = 1'b1;
    readAll("R1 regs after reset");

    // R3 latency and R2 mapping: line 5 -> bank1 bit5
    busWrite(12'h024, sw(32'h0000_0020));
    @(negedge clk); irqIn[5] = 1'b1;
    @(negedge clk); chk("R3 irq after 1 edge", 32'(irqOut), 0);
    @(negedge clk); chk("R3 irq after 2 edges", 32'(irqOut), 0);
    @(negedge clk); chk("R3 irq after 3 edges", 32'(irqOut), 1);
    mEvt[1] |= 32'h20; mLvl[1] |= 32'h20;
    readChk("R2 bank1 events", 12'h020);
    readChk("R2 bank0 events", 12'h010);
    setLines(64'h0000_0020_0000_0020); // line 37 -> bank0 bit5
    readChk("R2 bank0 bit5", 12'h010);
    readChk("R2 bank0 levels", 12'h01C);

    // R4: falling line keeps event
    setLines(64'h0);
    readChk("R4 event sticky", 12'h020);
    readChk("R4 levels cleared", 12'h02C);
    chk("R4 irq still high", 32'(irqOut), 32'(expIrq()));

    // R8 ack clears and irq drops
    busWrite(12'h028, sw(32'h0000_0020));
    busWrite(12'h018, sw(32'h0000_0020));
    readChk("R8 ack bank1", 12'h020);
    readChk("R8 ack bank0", 12'h010);
    chk("R8 irq low after ack", 32'(irqOut), 0);

    // R5 level bit 20 of bank1 (line 20)
    busWrite(12'h024, sw(32'h0010_0000));
    setLines(64'h0000_0000_0010_0000);
    readChk("R5 level not latched", 12'h020);
    chk("R5/R6 irq from level", 32'(irqOut), 1);
    busWrite(12'h028, sw(32'hFFFF_FFFF));
    chk("R8 ack ignores level", 32'(irqOut), 1);
    setLines(64'h0);
    chk("R5 irq follows level low", 32'(irqOut), 0);

    // R8 capture collides with ack: line 40 -> bank0 bit8
    busWrite(12'h014, sw(32'h0000_0100));
    @(negedge clk); irqIn[40] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busAddr = 12'h018; busWrData = sw(32'h0000_0100); busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
    mEvt[0] |= 32'h100; mLvl[0] = 32'h100;
    readChk("R8 capture wins", 12'h010);
    chk("R8 irq after collision", 32'(irqOut), 1);

    // R10 byte order: bus 0x00010000 -> internal bit 8 of mask
    busWrite(12'h014, 32'h0001_0000);
    chk("R10 swapped mask enables bit8", 32'(irqOut), 1);
    busWrite(12'h014, 32'h0000_0100);
    chk("R10 swapped mask misses bit8", 32'(irqOut), 0);
    readChk("R10 mask readback", 12'h014);

    // R9 odd addresses and ack read, R11 read before write in same cycle
    readChk("R9 ack reads zero", 12'h018);
    readChk("R9 offset 5 zero", 12'h015);
    readChk("R9 below window", 12'h00C);
    readChk("R9 above window", 12'h030);
    busWrite(12'h034, 32'hFFFF_FFFF);
    busWrite(12'h015, 32'hFFFF_FFFF);
    readAll("R9 stray writes ignored");
    @(negedge clk);
    busAddr = 12'h024; busWrData = 32'hA5A5_0000; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
    chk("R11 read shows old mask", busRdData, sw(mMask[1]));
    modelWrite(12'h024, 32'hA5A5_0000);
    @(negedge clk);
    chk("R11 read shows new mask", busRdData, sw(mMask[1]));

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 4);
      logic [11:0] a;
      case (op)
        0: setLines(irqIn ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}));
        1: busWrite(($urandom % 2) ? 12'h014 : 12'h024, $urandom);
        2: busWrite(($urandom % 2) ? 12'h018 : 12'h028, $urandom | $urandom);
        default: begin
          a = 12'($urandom % 64);
          if ($urandom % 2) busWrite(a, $urandom);
        end
      endcase
      chk("R6 random irq", 32'(irqOut), 32'(expIrq()));
      a = 12'($urandom % 64);
      readChk("R9 random read", a);
    end
    readAll("R4 final state");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule